// File: doc/BRIEF.md
# Microcoded Memory Timing Sequencer

This block produces the control waveforms for an external memory from microcode that software loads. A 64-word by 32-bit pattern store holds the microcode. Each word fixes the chip-select, the two byte-selects and four general-purpose lines for one bus clock, and each of the four quarter phases of that bus clock has its own field. The block runs on a clock four times the bus clock. A free-running two-bit phase counter sets the quarter-phase enables, and every output is registered.

A pattern starts when the engine is idle, at the end of a bus clock. Four sources can start one: an exception request, a refresh-timer request, a software run command with its own start index, and a memory access whose kind selects a fixed start offset. The engine then steps through consecutive words until it runs a word marked last. A word can also carry a wait-enable flag. In that case a synchronised external wait input freezes the engine on that word for as many whole bus clocks as wait stays high. The pattern store is written through a simple port, and only while the engine is idle.

Top module: `mseq_top`

## Requirements
- R1: After reset the lines are idle (cs_n=1, bs_n=2'b11, gp=0) and busy is 0.
- R2: A write with wr_en=1 while busy=0 stores wr_data at wr_addr. Word layout: quarter phase p uses bits [7p+6:7p] as {gp[3:0], bs_n[1:0], cs_n}, bit 28 is wait-enable, bit 29 is last, and bits 31:30 are unused.
- R3: A pattern starts only at the end of a bus clock (four clk cycles). busy rises together with the phase-0 cycle of the first word. The fields for phases 0, 1, 2 and 3 of each word appear on the lines in four consecutive clk cycles, each one clk cycle after its phase.
- R4: While the current word has last=0, the engine goes on to the word at the next index after its four phases. After a word with last=1, busy falls, the phase-3 field stays on the lines for one more cycle, and the lines then return to idle.
- R5: In operating mode 2'b00 an access request starts at 0x00 for acc_kind 0 (single read), 0x08 for kind 1 (burst read), 0x18 for kind 2 (single write) and 0x20 for kind 3 (burst write).
- R6: A refresh request starts at 0x30, an exception request starts at 0x3C, and a run command starts at run_idx.
- R7: When several requests are pending at the same time, the exception wins first, then refresh, then the run command, then the access.
- R8: In operating modes 2'b01, 2'b10 and 2'b11 an access request is ignored: busy stays 0 and the lines stay idle.
- R9: wait_in passes through a two-flop synchronizer. If the current word has wait-enable set and the synchronised wait is high at the end of the word's fourth phase, the word repeats for another bus clock instead of advancing.
- R10: A word without wait-enable never stalls, and a word with wait-enable does not stall when wait is low.
- R11: A write to the pattern store while busy=1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, four times the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| op_mode | input | 2 | Operating mode; 2'b00 is normal |
| acc_req | input | 1 | Memory access request (level) |
| acc_kind | input | 2 | Access kind selecting the start offset |
| ref_req | input | 1 | Refresh-timer request (level) |
| exc_req | input | 1 | Exception request (level) |
| run_cmd | input | 1 | Software run command (level) |
| run_idx | input | 6 | Start index for the run command |
| wait_in | input | 1 | External asynchronous wait |
| wr_en | input | 1 | Pattern store write enable |
| wr_addr | input | 6 | Pattern store write address |
| wr_data | input | 32 | Pattern store write data |
| cs_n | output | 1 | Chip-select, active low |
| bs_n | output | 2 | Byte-selects, active low |
| gp | output | 4 | General-purpose lines |
| busy | output | 1 | A pattern is running |

## Verification
The hardest case to reach from the ports is a stall whose length depends on exactly when wait falls relative to the synchronizer delay. The bench holds wait high before starting a burst-read pattern whose second word has wait-enable set. It lowers wait in the phase-2 cycle of the first repeated word. The two-flop delay then forces exactly one further repetition, so the word shows three times in all, and a one-flop design would show it only twice. Writes that are to be ignored are issued in the middle of a running pattern to a word that has not yet been output. The pattern is then run again to confirm the stored word kept its contents.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
    localparam int DEPTH = 64;
    localparam int AW    = $clog2(DEPTH);
    localparam int WW    = 32;
    localparam int NPH   = 4;
    localparam int PHW   = $clog2(NPH);
    localparam int GPW   = 4;
    localparam int BSW   = 2;
    localparam int LW    = GPW + BSW + 1;
    localparam int SPW   = WW - 2 - NPH * LW;

    typedef struct packed {
        logic [GPW-1:0] gp;
        logic [BSW-1:0] bs_n;
        logic           cs_n;
    } lines_t;

    localparam lines_t LINES_IDLE = '{gp: '0, bs_n: '1, cs_n: 1'b1};

    typedef struct packed {
        logic [SPW-1:0]       spare;
        logic                 last;
        logic                 wait_en;
        lines_t [NPH-1:0]     slot;
    } pword_t;

    typedef enum logic [2:0] {
        SRC_NONE, SRC_EXC, SRC_REF, SRC_RUN, SRC_ACC
    } src_e;

    localparam logic [AW-1:0] ST_RD_ONE  = AW'(8'h00);
    localparam logic [AW-1:0] ST_RD_BST  = AW'(8'h08);
    localparam logic [AW-1:0] ST_WR_ONE  = AW'(8'h18);
    localparam logic [AW-1:0] ST_WR_BST  = AW'(8'h20);
    localparam logic [AW-1:0] ST_REFRESH = AW'(8'h30);
    localparam logic [AW-1:0] ST_EXCEPT  = AW'(8'h3C);

    localparam logic [1:0] MODE_NORMAL = 2'b00;

    function automatic logic [AW-1:0] access_start(input logic [1:0] kind);
        case (kind)
            2'd0:    return ST_RD_ONE;
            2'd1:    return ST_RD_BST;
            2'd2:    return ST_WR_ONE;
            default: return ST_WR_BST;
        endcase
    endfunction
endpackage

// File: rtl/mseq_store.sv
module mseq_store
    import mseq_pkg::*;
(
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [WW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output pword_t        rword
);
    logic [WW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rword = pword_t'(mem[raddr]);
endmodule

// File: rtl/mseq_arb.sv
module mseq_arb
    import mseq_pkg::*;
(
    input  logic          exc,
    input  logic          refr,
    input  logic          run,
    input  logic [AW-1:0] run_idx,
    input  logic          acc,
    input  logic [1:0]    acc_kind,
    input  logic [1:0]    mode,
    output logic          valid,
    output logic [AW-1:0] start,
    output src_e          src
);
    always_comb begin
        valid = 1'b1;
        start = '0;
        src   = SRC_NONE;
        if (exc) begin
            src   = SRC_EXC;
            start = ST_EXCEPT;
        end else if (refr) begin
            src   = SRC_REF;
            start = ST_REFRESH;
        end else if (run) begin
            src   = SRC_RUN;
            start = run_idx;
        end else if (acc && mode == MODE_NORMAL) begin
            src   = SRC_ACC;
            start = access_start(acc_kind);
        end else begin
            valid = 1'b0;
        end
    end
endmodule

// File: rtl/mseq_sync.sv
module mseq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= din;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= 1'b0;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/mseq_drive.sv
module mseq_drive
    import mseq_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           active,
    input  pword_t         word,
    output logic [PHW-1:0] ph,
    output lines_t         lines
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ph    <= '0;
            lines <= LINES_IDLE;
        end else begin
            ph    <= ph + PHW'(1);
            lines <= active ? word.slot[ph] : LINES_IDLE;
        end
    end
endmodule

// File: rtl/mseq_top.sv
module mseq_top
    import mseq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    op_mode,
    input  logic          acc_req,
    input  logic [1:0]    acc_kind,
    input  logic          ref_req,
    input  logic          exc_req,
    input  logic          run_cmd,
    input  logic [5:0]    run_idx,
    input  logic          wait_in,
    input  logic          wr_en,
    input  logic [5:0]    wr_addr,
    input  logic [31:0]   wr_data,
    output logic          cs_n,
    output logic [1:0]    bs_n,
    output logic [3:0]    gp,
    output logic          busy
);
    logic           active;
    logic [AW-1:0]  idx;
    pword_t         cur_word;
    logic [PHW-1:0] ph;
    lines_t         drv_q;
    logic           wait_s;
    logic           grant_v;
    logic [AW-1:0]  grant_idx;
    src_e           grant_src;
    logic           clk_end;
    logic           stall;

    mseq_store u_store (
        .clk   (clk),
        .we    (wr_en && !active),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (idx),
        .rword (cur_word)
    );

    mseq_arb u_arb (
        .exc      (exc_req),
        .refr     (ref_req),
        .run      (run_cmd),
        .run_idx  (run_idx),
        .acc      (acc_req),
        .acc_kind (acc_kind),
        .mode     (op_mode),
        .valid    (grant_v),
        .start    (grant_idx),
        .src      (grant_src)
    );

    mseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (wait_in),
        .dout (wait_s)
    );

    mseq_drive u_drive (
        .clk    (clk),
        .rst    (rst),
        .active (active),
        .word   (cur_word),
        .ph     (ph),
        .lines  (drv_q)
    );

    assign clk_end = (ph == PHW'(NPH - 1));
    assign stall   = cur_word.wait_en && wait_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            idx    <= '0;
        end else if (clk_end) begin
            if (active) begin
                if (!stall) begin
                    if (cur_word.last) active <= 1'b0;
                    else               idx    <= idx + AW'(1);
                end
            end else if (grant_v && grant_src != SRC_NONE) begin
                active <= 1'b1;
                idx    <= grant_idx;
            end
        end
    end

    assign cs_n = drv_q.cs_n;
    assign bs_n = drv_q.bs_n;
    assign gp   = drv_q.gp;
    assign busy = active;
endmodule

// File: rtl/mseq_chk.sv
module mseq_chk
    import mseq_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           busy,
    input logic [PHW-1:0] ph,
    input logic [AW-1:0]  idx,
    input pword_t         cur,
    input logic           wsync,
    input logic           exc_req,
    input lines_t         lines
);
    assert_start_on_phase0_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ph == '0);

    assert_idle_lines_R4: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(busy)) |-> lines == LINES_IDLE);

    assert_last_ends_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && ph == PHW'(NPH - 1) && cur.last && !(cur.wait_en && wsync)) |=> !busy);

    assert_stall_holds_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && ph == PHW'(NPH - 1) && cur.wait_en && wsync) |=> (busy && $stable(idx)));

    assert_idx_steady_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && ph != '0) |-> $stable(idx));

    assert_exc_first_R7: assert property (@(posedge clk) disable iff (rst)
        ($rose(busy) && $past(exc_req)) |-> idx == ST_EXCEPT);
endmodule

bind mseq_top mseq_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .busy    (busy),
    .ph      (ph),
    .idx     (idx),
    .cur     (cur_word),
    .wsync   (wait_s),
    .exc_req (exc_req),
    .lines   (drv_q)
);

// File: tb/mseq_top_tb.sv
module mseq_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  op_mode = 2'b00;
    logic        acc_req = 1'b0;
    logic [1:0]  acc_kind = 2'd0;
    logic        ref_req = 1'b0;
    logic        exc_req = 1'b0;
    logic        run_cmd = 1'b0;
    logic [5:0]  run_idx = 6'd0;
    logic        wait_in = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = 6'd0;
    logic [31:0] wr_data = 32'd0;
    logic        cs_n;
    logic [1:0]  bs_n;
    logic [3:0]  gp;
    logic        busy;

    int nvec = 0;
    int nbad = 0;
    logic [31:0] img [64];
    int exp_addr [64];
    int nslots;
    int drop_at = -1;
    int wr_at = -1;

    always #10 clk = ~clk;

    mseq_top u_dut (
        .clk(clk), .rst(rst), .op_mode(op_mode), .acc_req(acc_req),
        .acc_kind(acc_kind), .ref_req(ref_req), .exc_req(exc_req),
        .run_cmd(run_cmd), .run_idx(run_idx), .wait_in(wait_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cs_n(cs_n), .bs_n(bs_n), .gp(gp), .busy(busy)
    );

    task automatic chk(string req, int act, int exp);
        nvec++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] fld(int a, int p);
        return 7'((a * 7 + p * 13 + 5) % 128);
    endfunction

    function automatic bit is_last(int a);
        return a == 'h03 || a == 'h0F || a == 'h1B || a == 'h27 ||
               a == 'h35 || a == 'h3F || a == 'h12;
    endfunction

    function automatic logic [31:0] mkword(int a);
        return {2'b00, is_last(a), (a == 'h09), fld(a, 3), fld(a, 2), fld(a, 1), fld(a, 0)};
    endfunction

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 6'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_seq(int first, int last);
        nslots = last - first + 1;
        for (int i = 0; i < nslots; i++) exp_addr[i] = first + i;
    endtask

    function automatic int lines_now();
        return int'({gp, bs_n, cs_n});
    endfunction

    task automatic clear_reqs();
        acc_req = 1'b0; ref_req = 1'b0; exc_req = 1'b0; run_cmd = 1'b0;
    endtask

    // Waits for busy, then compares every quarter-phase output against img.
    task automatic capture(string req);
        int guard = 0;
        bit busy_ok = 1'b1;
        int j;
        while (busy !== 1'b1 && guard < 40) begin
            @(negedge clk);
            guard++;
        end
        chk({req, " start"}, int'(busy), 1);
        clear_reqs();
        for (j = 0; j < 4 * nslots; j++) begin
            @(negedge clk);
            chk(req, lines_now(), int'(img[exp_addr[j / 4]][7 * (j % 4) +: 7]));
            if (j < 4 * nslots - 1 && busy !== 1'b1) busy_ok = 1'b0;
            if (j == drop_at) wait_in = 1'b0;
            if (j == wr_at) begin
                wr_en = 1'b1; wr_addr = 6'(exp_addr[nslots - 1]); wr_data = 32'h0;
            end
            if (j == wr_at + 1) wr_en = 1'b0;
        end
        chk({req, " busy length R4"}, int'(busy_ok), 1);
        chk({req, " busy end R4"}, int'(busy), 0);
        @(negedge clk);
        chk({req, " idle after R4"}, lines_now(), 7'b0000111);
        drop_at = -1;
        wr_at = -1;
    endtask

    initial begin
        #(20 * 200000);
        nbad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 lines", lines_now(), 7'b0000111);
        chk("R1 busy", int'(busy), 0);

        // R2 load store while idle
        for (int a = 0; a < 64; a++) begin
            img[a] = mkword(a);
            wr(a, img[a]);
        end

        // R5 all access kinds in normal mode, R10 wait low with wait-enable word
        for (int k = 0; k < 4; k++) begin
            op_mode = 2'b00; acc_kind = 2'(k); acc_req = 1'b1;
            case (k)
                0: set_seq('h00, 'h03);
                1: set_seq('h08, 'h0F);
                2: set_seq('h18, 'h1B);
                default: set_seq('h20, 'h27);
            endcase
            capture(k == 1 ? "R5 R10 burst read" : "R5 access");
        end

        // R6 refresh, exception, run command
        ref_req = 1'b1; set_seq('h30, 'h35); capture("R6 refresh");
        exc_req = 1'b1; set_seq('h3C, 'h3F); capture("R6 exception");
        run_idx = 6'h10; run_cmd = 1'b1; set_seq('h10, 'h12); capture("R6 run");

        // R7 priority combinations
        @(negedge clk);
        exc_req = 1'b1; ref_req = 1'b1; run_cmd = 1'b1; acc_req = 1'b1; acc_kind = 2'd0;
        set_seq('h3C, 'h3F); capture("R7 exc wins");
        ref_req = 1'b1; run_cmd = 1'b1; acc_req = 1'b1;
        set_seq('h30, 'h35); capture("R7 refresh wins");
        run_cmd = 1'b1; acc_req = 1'b1;
        set_seq('h10, 'h12); capture("R7 run wins");

        // R8 access ignored outside normal mode
        for (int m = 1; m < 4; m++) begin
            for (int k = 0; k < 4; k++) begin
                bit quiet = 1'b1;
                op_mode = 2'(m); acc_kind = 2'(k); acc_req = 1'b1;
                for (int c = 0; c < 10; c++) begin
                    @(negedge clk);
                    if (busy !== 1'b0 || lines_now() != 7'b0000111) quiet = 1'b0;
                end
                acc_req = 1'b0;
                chk("R8 ignored access", int'(quiet), 1);
            end
        end
        op_mode = 2'b00;

        // R9 stall: word 0x09 repeats three times given the drop timing
        wait_in = 1'b1;
        repeat (4) @(negedge clk);
        acc_kind = 2'd1; acc_req = 1'b1;
        nslots = 10;
        exp_addr[0] = 'h08; exp_addr[1] = 'h09; exp_addr[2] = 'h09; exp_addr[3] = 'h09;
        for (int i = 4; i < 10; i++) exp_addr[i] = 'h0A + i - 4;
        drop_at = 9;
        capture("R9 stall");

        // R11 write during pattern ignored, then rerun
        acc_kind = 2'd0; acc_req = 1'b1; set_seq('h00, 'h03); wr_at = 0;
        capture("R11 during");
        acc_kind = 2'd0; acc_req = 1'b1; set_seq('h00, 'h03);
        capture("R11 rerun");

        // R2 idle write takes effect
        img['h11] = img['h11] ^ 32'h0ABCDEF1;
        img['h11][29:28] = 2'b00;
        wr('h11, img['h11]);
        run_idx = 6'h10; run_cmd = 1'b1; set_seq('h10, 'h12);
        capture("R2 rewrite");

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule